// File: doc/BRIEF.md
# Buzzer Scale Sequencer

This block walks a passive buzzer through a fixed musical scale. For each note it produces the settings that a downstream PWM generator needs: a period reload value, a compare value and an enable. The scale covers seven notes in each of three octaves, 21 steps in all. Each note is held for a fixed dwell time. After the last note of the top octave the scale starts again at the first note of the bottom octave.

The compare value is always half the reload value, so the buzzer receives a square wave with a 50 % duty cycle. It never receives a steady level. The only control input is a play level, and the block's pins carry no data stream. When play is low, the scale goes back to its first note and the PWM generator is turned off. When play is raised, the scale starts from that first note with a full dwell.

Top module: `tone_sequencer`

## Requirements
- R1: After reset, `note_idx_o` is 0, `pwm_en_o` is 0, `pwm_reload_o` holds the reload value of index 0 and `pwm_compare_o` holds half of it.
- R2: The reload value for index i is CLK_HZ / f(i) - 1, using integer division. For i = 7*k + n, f(i) is base(n) multiplied by 2^k. The bases for n = 0..6 are 131, 147, 165, 175, 196, 220 and 247 Hz. Index 0..6 is the low octave, 7..13 the middle octave and 14..20 the high octave.
- R3: `pwm_compare_o` always equals `pwm_reload_o` shifted right by one bit.
- R4: While play is high, each index is shown for exactly DWELL_CYCLES clock cycles, and then the index goes up by one.
- R5: After index 20 has been held for its dwell, the next index is 0.
- R6: While playing, the reload and compare outputs change only in the cycle that follows the end of a dwell, and they change together.
- R7: One cycle after play is sampled low, the index is 0, the dwell timer is cleared and the outputs carry the index 0 settings. These values stay put for as long as play stays low.
- R8: `pwm_en_o` equals the play input delayed by one cycle. While it is high, the compare value is nonzero and smaller than the reload value, so the output is never a DC level.
- R9: After play is lowered and raised again, index 0 is held for a full dwell before the scale moves on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| play_en | input | 1 | High to play the scale, low to stop and rewind |
| pwm_reload_o | output | 32 | Period reload value for the PWM generator |
| pwm_compare_o | output | 32 | Compare value for the PWM generator, half of the reload |
| pwm_en_o | output | 1 | Enable for the PWM generator |
| note_idx_o | output | 5 | Index of the current note, 0 to 20 |

## Verification
The bench first plays the scale for more than one full lap with play held high. It samples every cycle, which separates a correct dwell length from one that is off by one, and shows whether the wrap goes from 20 back to 0 or overruns. It then drops play in the middle of a dwell and holds it low for several dwell lengths. This shows whether the rewind happens at once and whether the timer keeps running while idle. Last, it raises play again and checks that the first note gets a full dwell rather than the leftover of the old count.

// File: rtl/tone_seq_pkg.sv
package tone_seq_pkg;

  localparam int NOTES_PER_OCTAVE = 7;
  localparam int SETPOINT_W       = 32;

  // base pitch of scale degree n (0..6) in the lowest octave, in Hz
  function automatic int degree_hz(input int n);
    case (n)
      0:       return 131;
      1:       return 147;
      2:       return 165;
      3:       return 175;
      4:       return 196;
      5:       return 220;
      default: return 247;
    endcase
  endfunction

  // pitch of table entry i: degree times a power of two for the octave
  function automatic int entry_hz(input int i);
    return degree_hz(i % NOTES_PER_OCTAVE) << (i / NOTES_PER_OCTAVE);
  endfunction

  // reload count for table entry i at the given clock rate
  function automatic int entry_reload(input int clk_hz, input int i);
    return clk_hz / entry_hz(i) - 1;
  endfunction

endpackage

// File: rtl/tone_dwell_timer.sv
module tone_dwell_timer #(
  parameter  int DWELL_CYCLES = 25_000_000,
  localparam int CNT_W        = $clog2(DWELL_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic adv_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);
  assign adv_o  = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || at_end)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R4
  AST_TIMER_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));  // R7
  AST_ADV_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> !adv_o);  // R4
  AST_ADV_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |=> (cnt_q == '0));  // R4

endmodule

// File: rtl/tone_note_stepper.sv
module tone_note_stepper #(
  parameter  int NUM_NOTES = 21,
  localparam int IDX_W     = $clog2(NUM_NOTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_next_o
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_NOTES - 1);

  logic [IDX_W-1:0] idx_q;

  assign idx_next_o = (idx_q == TOP) ? '0 : idx_q + 1'b1;
  assign idx_o      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (!run)  idx_q <= '0;
    else if (adv)   idx_q <= idx_next_o;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= TOP);  // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx_q == TOP) |=> (idx_q == '0));  // R5
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx_q != TOP) |=> (idx_q == $past(idx_q) + 1'b1));  // R4
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> $stable(idx_q));  // R4
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (idx_q == '0));  // R7

endmodule

// File: rtl/tone_period_table.sv
module tone_period_table
  import tone_seq_pkg::*;
#(
  parameter  int CLK_HZ    = 50_000_000,
  parameter  int NUM_NOTES = 21,
  localparam int IDX_W     = $clog2(NUM_NOTES)
) (
  input  logic [IDX_W-1:0]      idx,
  output logic [SETPOINT_W-1:0] reload_o
);

  logic [SETPOINT_W-1:0] entries [NUM_NOTES];

  for (genvar g = 0; g < NUM_NOTES; g++) begin : g_entry
    assign entries[g] = SETPOINT_W'(entry_reload(CLK_HZ, g));
  end

  always_comb begin
    reload_o = entries[0];
    for (int i = 0; i < NUM_NOTES; i++) begin
      if (idx == IDX_W'(i)) reload_o = entries[i];
    end
  end

endmodule

// File: rtl/tone_pwm_setpoint.sv
module tone_pwm_setpoint
  import tone_seq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  adv,
  input  logic [SETPOINT_W-1:0] next_reload,
  output logic [SETPOINT_W-1:0] reload_o,
  output logic [SETPOINT_W-1:0] compare_o,
  output logic                  en_o
);

  localparam logic [SETPOINT_W-1:0] FIRST_RELOAD = SETPOINT_W'(entry_reload(CLK_HZ, 0));

  logic [SETPOINT_W-1:0] reload_q;
  logic [SETPOINT_W-1:0] compare_q;
  logic                  en_q;
  logic                  load;

  // idle loads the first entry; a dwell end loads the upcoming one
  assign load = !run || adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= FIRST_RELOAD;
      compare_q <= FIRST_RELOAD >> 1;
      en_q      <= 1'b0;
    end else begin
      en_q <= run;
      if (load) begin
        reload_q  <= next_reload;
        compare_q <= next_reload >> 1;
      end
    end
  end

  assign reload_o  = reload_q;
  assign compare_o = compare_q;
  assign en_o      = en_q;

  AST_SETPOINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> ($stable(reload_q) && $stable(compare_q)));  // R6
  AST_EN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> en_q);  // R8
  AST_EN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !en_q);  // R8
  AST_IDLE_FIRST_NOTE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (reload_q == FIRST_RELOAD));  // R7

endmodule

// File: rtl/tone_sequencer.sv
module tone_sequencer
  import tone_seq_pkg::*;
#(
  parameter  int CLK_HZ       = 50_000_000,
  parameter  int DWELL_CYCLES = 25_000_000,
  parameter  int NUM_OCTAVES  = 3,
  localparam int NUM_NOTES    = NOTES_PER_OCTAVE * NUM_OCTAVES,
  localparam int IDX_W        = $clog2(NUM_NOTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             play_en,
  output logic [31:0]      pwm_reload_o,
  output logic [31:0]      pwm_compare_o,
  output logic             pwm_en_o,
  output logic [IDX_W-1:0] note_idx_o
);

  logic                  adv;
  logic [IDX_W-1:0]      idx_cur;
  logic [IDX_W-1:0]      idx_next;
  logic [IDX_W-1:0]      lookup_idx;
  logic [SETPOINT_W-1:0] lookup_reload;

  tone_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (play_en),
    .adv_o (adv)
  );

  tone_note_stepper #(.NUM_NOTES(NUM_NOTES)) u_stepper (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (play_en),
    .adv        (adv),
    .idx_o      (idx_cur),
    .idx_next_o (idx_next)
  );

  // while idle the table is pointed at the first entry
  assign lookup_idx = play_en ? idx_next : '0;

  tone_period_table #(.CLK_HZ(CLK_HZ), .NUM_NOTES(NUM_NOTES)) u_table (
    .idx      (lookup_idx),
    .reload_o (lookup_reload)
  );

  tone_pwm_setpoint #(.CLK_HZ(CLK_HZ)) u_setpoint (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (play_en),
    .adv         (adv),
    .next_reload (lookup_reload),
    .reload_o    (pwm_reload_o),
    .compare_o   (pwm_compare_o),
    .en_o        (pwm_en_o)
  );

  assign note_idx_o = idx_cur;

  AST_HALF_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_compare_o == (pwm_reload_o >> 1));  // R3
  AST_NO_DC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en_o |-> (pwm_compare_o != 0 && pwm_compare_o < pwm_reload_o));  // R8
  AST_SETPOINT_WITH_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && $changed(note_idx_o)) |-> $changed(pwm_reload_o));  // R6

endmodule

// File: tb/tone_sequencer_bench.sv
module tone_sequencer_bench;

  localparam int CLK_HZ = 50_000_000;
  localparam int D      = 16;
  localparam int N      = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        play_en = 1'b0;
  logic [31:0] pwm_reload_o;
  logic [31:0] pwm_compare_o;
  logic        pwm_en_o;
  logic [4:0]  note_idx_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tone_sequencer #(.CLK_HZ(CLK_HZ), .DWELL_CYCLES(D), .NUM_OCTAVES(3)) u_tone_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .play_en       (play_en),
    .pwm_reload_o  (pwm_reload_o),
    .pwm_compare_o (pwm_compare_o),
    .pwm_en_o      (pwm_en_o),
    .note_idx_o    (note_idx_o)
  );

  // expected reload from the pitch rule of R2
  function automatic longint exp_reload(input int i);
    int base;
    case (i % 7)
      0: base = 131;
      1: base = 147;
      2: base = 165;
      3: base = 175;
      4: base = 196;
      5: base = 220;
      default: base = 247;
    endcase
    return longint'(CLK_HZ / (base << (i / 7)) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the settings of note i
  task automatic chk_note(input int i, input bit en, input string req);
    chk(note_idx_o == 5'(i), req, note_idx_o, i);
    chk(longint'(pwm_reload_o) == exp_reload(i), {req, " R2 reload"}, pwm_reload_o, exp_reload(i));
    chk(longint'(pwm_compare_o) == exp_reload(i) / 2, {req, " R3 compare"}, pwm_compare_o, exp_reload(i) / 2);
    chk(pwm_en_o == en, {req, " R8 enable"}, pwm_en_o, en);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_note(0, 1'b0, "R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_note(0, 1'b0, "R1 after release");
  endtask

  // full lap plus one note: dwell length, order, wrap, change points
  task automatic t_scale_lap;
    longint prev;
    play_en = 1'b1;
    chk(pwm_en_o == 1'b0, "R8 before first edge", pwm_en_o, 0);
    prev = pwm_reload_o;
    for (int k = 1; k <= (N + 1) * D; k++) begin
      @(negedge clk);
      chk_note((k / D) % N, 1'b1, "R4 R5 lap");
      if (k % D != 0)
        chk(longint'(pwm_reload_o) == prev, "R6 held inside dwell", pwm_reload_o, prev);
      prev = pwm_reload_o;
    end
  endtask

  // drop play mid-dwell, stay idle a while
  task automatic t_pause;
    repeat (D / 2) @(negedge clk);
    play_en = 1'b0;
    @(negedge clk);
    chk_note(0, 1'b0, "R7 rewind");
    for (int k = 0; k < 3 * D; k++) begin
      @(negedge clk);
      chk_note(0, 1'b0, "R7 idle hold");
    end
  endtask

  // restart gives the first note a full dwell
  task automatic t_restart;
    play_en = 1'b1;
    for (int k = 1; k <= 2 * D; k++) begin
      @(negedge clk);
      chk_note(k / D, 1'b1, "R9 restart");
    end
    play_en = 1'b0;
    @(negedge clk);
    chk_note(0, 1'b0, "R7 stop again");
  endtask

  initial begin
    t_reset();
    t_scale_lap();
    t_pause();
    t_restart();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule